// File: doc/BRIEF.md
# Two-Class Dual-Issue Controller

This block sits at the issue stage of an in-order pipeline. Each cycle it looks at a fetch group of two instructions from an aligned pair and decides which of them issue. Slot 0 holds the older instruction and slot 1 the younger. Each instruction carries a one-bit class tag that was set when the line was filled: either a floating-point ALU operation or any other instruction. Because the two classes never share operands, the controller makes no dependence check between the slots. Pairing depends on the class tags alone. Either class may sit in either slot.

At most one instruction per class issues in a cycle. The controller never reorders instructions and never issues speculatively. Suppose an instruction needs a long-latency unit (the integer multiply/divide unit or the floating-point divide/square-root unit) and that unit reports busy. Then the instruction waits, and every younger instruction waits behind it. While any valid instruction of the group has not yet issued, the block raises `slip`. The fetch side must then hold the same group on the inputs. The block remembers internally which slots of the held group have already gone.

An entry at a branch target in the odd slot is shown to the block with slot 0 marked invalid. Only slot 1 can issue in that case.

Top module: `dual_issue_ctl`

## Requirements
- R1: While `rst_n` is low, all issue strobes and `slip` are 0 when no slot is valid. After reset, a group on the inputs is treated as fresh: no slot counts as already issued, even if reset cut a held group short.
- R2: Class bit `slot_fp[k]` = 1 means floating-point ALU and 0 means any other instruction. Slot k can issue only on the port of its own class: `fp_issue[k]` for class 1, `int_issue[k]` for class 0. Bit k of each strobe vector belongs to slot k.
- R3: If both slots are valid, their classes differ and neither is blocked, both issue in the same cycle and `slip` is 0.
- R4: If both slots are valid and share a class, only slot 0 issues in that cycle and `slip` is 1. In the next cycle, with the same group held, slot 1 issues and `slip` falls to 0.
- R5: An invalid slot never issues. A group with only slot 1 valid issues slot 1 alone without slip. A group with no valid slot issues nothing and does not slip.
- R6: A slot is blocked when its `slot_lng` bit is 1 and the busy flag of its class's long-latency unit is 1 (`fp_busy` for class 1, `int_busy` for class 0). If pending slot 0 is blocked, nothing issues and `slip` stays 1 until the flag clears. Slot 1 never passes slot 0.
- R7: If only slot 1 is blocked, slot 0 issues and slot 1 waits with `slip` at 1. Slot 1 issues in the first cycle its unit is free.
- R8: A busy flag has no effect on a slot whose `slot_lng` bit is 0, and none on a slot of the other class.
- R9: `slip` is 1 exactly when a valid, not-yet-issued slot remains after this cycle's issue. A new group presented after `slip` was 0 is fresh.
- R10: Each port takes at most one strobe per cycle. Within one held group, no slot issues twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 2 | Valid bit per slot of the fetch group |
| slot_fp | input | 2 | Class tag per slot: 1 floating-point ALU, 0 other |
| slot_lng | input | 2 | Slot needs its class's long-latency unit |
| int_busy | input | 1 | Integer multiply/divide unit busy |
| fp_busy | input | 1 | Floating-point divide/square-root unit busy |
| int_issue | output | 2 | Per-slot strobe to the integer port |
| fp_issue | output | 2 | Per-slot strobe to the floating-point port |
| slip | output | 1 | Group not finished; fetch must hold it |

## Verification
The issue strobes and `slip` are combinational in the current inputs, so they are due in the same cycle as the group. The bench drives the inputs on the falling edge and samples one time unit later, before the next rising edge. The record of already-issued slots updates on the rising edge. Its effect therefore shows in the cycle after a slip, and each scenario task steps one falling edge while holding the group and checks the follow-up cycle there. Reset effects are sampled while reset is still low and again in the first cycle after release.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int SLOTS = 2;

  typedef enum logic {
    CLS_OTHER = 1'b0,
    CLS_FPALU = 1'b1
  } iclass_e;

  typedef struct packed {
    logic    vld;
    iclass_e cls;
    logic    lng;
  } slot_t;
endpackage

// File: rtl/dic_slot_qual.sv
module dic_slot_qual
  import dic_pkg::*;
(
  input  slot_t slot_i,
  input  logic  done_i,
  input  logic  int_busy_i,
  input  logic  fp_busy_i,
  output logic  pend_o,
  output logic  ready_o
);
  logic unit_busy;

  always_comb begin
    unit_busy = (slot_i.cls == CLS_FPALU) ? fp_busy_i : int_busy_i;
    pend_o    = slot_i.vld & ~done_i;
    ready_o   = pend_o & ~(slot_i.lng & unit_busy);
  end
endmodule

// File: rtl/dic_pair_pick.sv
module dic_pair_pick
  import dic_pkg::*;
(
  input  logic [SLOTS-1:0] pend_i,
  input  logic [SLOTS-1:0] ready_i,
  input  iclass_e          cls0_i,
  input  iclass_e          cls1_i,
  output logic [SLOTS-1:0] iss_o,
  output logic             slip_o
);
  logic same_cls;
  logic older_clear;

  always_comb begin
    same_cls    = (cls0_i == cls1_i);
    // younger slot may go only if the older one is gone or goes now on the other port
    older_clear = ~pend_i[0] | (ready_i[0] & ~same_cls);
    iss_o[0]    = ready_i[0];
    iss_o[1]    = ready_i[1] & older_clear;
    slip_o      = |(pend_i & ~iss_o);
  end
endmodule

// File: rtl/dic_done_track.sv
module dic_done_track
  import dic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] iss_i,
  input  logic             slip_i,
  output logic [SLOTS-1:0] done_o
);
  logic [SLOTS-1:0] done_q;
  logic [SLOTS-1:0] done_d;
  logic             done_en;

  always_comb begin
    done_en = slip_i | (|done_q);
    done_d  = slip_i ? (done_q | iss_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] slot_vld,
  input  logic [1:0] slot_fp,
  input  logic [1:0] slot_lng,
  input  logic       int_busy,
  input  logic       fp_busy,
  output logic [1:0] int_issue,
  output logic [1:0] fp_issue,
  output logic       slip
);
  slot_t            slots [SLOTS];
  logic [SLOTS-1:0] pend;
  logic [SLOTS-1:0] ready;
  logic [SLOTS-1:0] done;
  logic [SLOTS-1:0] iss;
  logic             slip_w;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      slots[k].vld = slot_vld[k];
      slots[k].cls = iclass_e'(slot_fp[k]);
      slots[k].lng = slot_lng[k];
    end

    dic_slot_qual u_qual (
      .slot_i     (slots[k]),
      .done_i     (done[k]),
      .int_busy_i (int_busy),
      .fp_busy_i  (fp_busy),
      .pend_o     (pend[k]),
      .ready_o    (ready[k])
    );

    always_comb begin
      int_issue[k] = iss[k] & (slots[k].cls == CLS_OTHER);
      fp_issue[k]  = iss[k] & (slots[k].cls == CLS_FPALU);
    end
  end

  dic_pair_pick u_pick (
    .pend_i  (pend),
    .ready_i (ready),
    .cls0_i  (slots[0].cls),
    .cls1_i  (slots[1].cls),
    .iss_o   (iss),
    .slip_o  (slip_w)
  );

  dic_done_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .iss_i  (iss),
    .slip_i (slip_w),
    .done_o (done)
  );

  assign slip = slip_w;
endmodule

// File: rtl/dic_checker.sv
module dic_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] slot_vld,
  input logic [1:0] slot_fp,
  input logic [1:0] slot_lng,
  input logic       int_busy,
  input logic       fp_busy,
  input logic [1:0] int_issue,
  input logic [1:0] fp_issue,
  input logic       slip
);
  logic       prev_slip;
  logic [1:0] prev_iss;
  logic [1:0] blk;
  logic [1:0] iss_any;
  logic       fresh;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      blk[k] = slot_lng[k] & (slot_fp[k] ? fp_busy : int_busy);
    end
    iss_any = int_issue | fp_issue;
    fresh   = ~prev_slip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_slip <= 1'b0;
      prev_iss  <= '0;
    end else begin
      prev_slip <= slip;
      prev_iss  <= iss_any;
    end
  end

  AST_ONE_PER_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_issue) && $onehot0(fp_issue)); // R10

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    prev_slip |-> ((prev_iss & iss_any) == 2'b00)); // R10

  AST_PORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((fp_issue & ~slot_fp) == 2'b00) && ((int_issue & slot_fp) == 2'b00)); // R2

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_any & ~slot_vld) == 2'b00); // R5

  AST_IDLE_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld == 2'b00) |-> !slip); // R9

  AST_OLDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && slot_vld[0] && blk[0]) |-> (iss_any == 2'b00 && slip)); // R6

  AST_YOUNGER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    blk[1] |-> !iss_any[1]); // R7

  AST_SAME_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && slot_vld == 2'b11 && slot_fp[0] == slot_fp[1]) |-> !iss_any[1]); // R4

  AST_FULL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && slot_vld == 2'b11 && slot_fp[0] != slot_fp[1] && blk == 2'b00)
      |-> (iss_any == 2'b11 && !slip)); // R3
endmodule

bind dual_issue_ctl dic_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_vld  (slot_vld),
  .slot_fp   (slot_fp),
  .slot_lng  (slot_lng),
  .int_busy  (int_busy),
  .fp_busy   (fp_busy),
  .int_issue (int_issue),
  .fp_issue  (fp_issue),
  .slip      (slip)
);

// File: tb/dual_issue_ctl_tb.sv
module dual_issue_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [1:0] slot_vld;
  logic [1:0] slot_fp;
  logic [1:0] slot_lng;
  logic       int_busy;
  logic       fp_busy;
  logic [1:0] int_issue;
  logic [1:0] fp_issue;
  logic       slip;

  int n_chk;
  int n_bad;
  bit finished;

  dual_issue_ctl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_vld  (slot_vld),
    .slot_fp   (slot_fp),
    .slot_lng  (slot_lng),
    .int_busy  (int_busy),
    .fp_busy   (fp_busy),
    .int_issue (int_issue),
    .fp_issue  (fp_issue),
    .slip      (slip)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic drive(input logic [1:0] v, input logic [1:0] c, input logic [1:0] l,
                       input logic ib, input logic fb);
    slot_vld = v; slot_fp = c; slot_lng = l; int_busy = ib; fp_busy = fb;
  endtask

  // sample 1 time unit after the falling-edge drive
  task automatic expect_out(input string tag, input logic [1:0] ei, input logic [1:0] ef,
                            input logic es);
    #1;
    n_chk++;
    if (int_issue !== ei || fp_issue !== ef || slip !== es) begin
      n_bad++;
      $display("FAIL %s: int=%b fp=%b slip=%b expected int=%b fp=%b slip=%b",
               tag, int_issue, fp_issue, slip, ei, ef, es);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    expect_out("R1 reset idle", 2'b00, 2'b00, 1'b0);
    rst_n = 1'b1;
    next_cycle();
  endtask

  task automatic t_mixed_pair();
    drive(2'b11, 2'b10, 2'b00, 1'b0, 1'b0);
    expect_out("R3 int+fp pair", 2'b01, 2'b10, 1'b0);
    next_cycle();
    drive(2'b11, 2'b01, 2'b00, 1'b0, 1'b0);
    expect_out("R2 fp+int pair ports", 2'b10, 2'b01, 1'b0);
    next_cycle();
  endtask

  task automatic t_same_class();
    drive(2'b11, 2'b00, 2'b00, 1'b0, 1'b0);
    expect_out("R4 int,int first", 2'b01, 2'b00, 1'b1);
    next_cycle();
    expect_out("R4 int,int second", 2'b10, 2'b00, 1'b0);
    next_cycle();
    drive(2'b11, 2'b11, 2'b00, 1'b0, 1'b0);
    expect_out("R4 fp,fp first", 2'b00, 2'b01, 1'b1);
    next_cycle();
    expect_out("R4 fp,fp second", 2'b00, 2'b10, 1'b0);
    next_cycle();
    drive(2'b11, 2'b00, 2'b00, 1'b0, 1'b0);
    expect_out("R9 fresh after finished group", 2'b01, 2'b00, 1'b1);
    next_cycle();
    expect_out("R9 finish second group", 2'b10, 2'b00, 1'b0);
    next_cycle();
  endtask

  task automatic t_invalid();
    drive(2'b10, 2'b10, 2'b00, 1'b0, 1'b0);
    expect_out("R5 odd entry slot1 only", 2'b00, 2'b10, 1'b0);
    next_cycle();
    drive(2'b10, 2'b00, 2'b00, 1'b0, 1'b0);
    expect_out("R5 odd entry int slot1", 2'b10, 2'b00, 1'b0);
    next_cycle();
    drive(2'b00, 2'b11, 2'b11, 1'b1, 1'b1);
    expect_out("R5 empty group", 2'b00, 2'b00, 1'b0);
    next_cycle();
  endtask

  task automatic t_older_busy();
    drive(2'b11, 2'b10, 2'b01, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      expect_out("R6 older blocked", 2'b00, 2'b00, 1'b1);
      next_cycle();
    end
    int_busy = 1'b0;
    expect_out("R6 release pair", 2'b01, 2'b10, 1'b0);
    next_cycle();
  endtask

  task automatic t_younger_busy();
    drive(2'b11, 2'b10, 2'b10, 1'b0, 1'b1);
    expect_out("R7 older goes", 2'b01, 2'b00, 1'b1);
    next_cycle();
    expect_out("R7 younger waits", 2'b00, 2'b00, 1'b1);
    next_cycle();
    fp_busy = 1'b0;
    expect_out("R7 younger goes", 2'b00, 2'b10, 1'b0);
    next_cycle();
  endtask

  task automatic t_busy_ignored();
    drive(2'b11, 2'b10, 2'b01, 1'b0, 1'b1);
    expect_out("R8 other-class busy", 2'b01, 2'b10, 1'b0);
    next_cycle();
    drive(2'b11, 2'b10, 2'b00, 1'b1, 1'b1);
    expect_out("R8 no long unit needed", 2'b01, 2'b10, 1'b0);
    next_cycle();
  endtask

  task automatic t_reset_mid_hold();
    drive(2'b11, 2'b00, 2'b00, 1'b0, 1'b0);
    expect_out("R4 hold before reset", 2'b01, 2'b00, 1'b1);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    expect_out("R1 group fresh after reset", 2'b01, 2'b00, 1'b1);
    next_cycle();
    expect_out("R10 second slot once", 2'b10, 2'b00, 1'b0);
    next_cycle();
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    drive(2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    t_reset();
    t_mixed_pair();
    t_same_class();
    t_invalid();
    t_older_busy();
    t_younger_busy();
    t_busy_ignored();
    t_reset_mid_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule